// File: doc/BRIEF.md
# Edge-Counting Timer

This block is a free-running timer that can also act as an event counter. In timer mode a prescale counter runs on every clock. Each time it passes its programmed limit it wraps to zero and the main count advances. In counter mode the prescaler is bypassed, and the main count advances on edges of one of two asynchronous capture pins. Each pin is synchronized, and an edge is found by comparing two consecutive synchronized samples. The mode field selects rising edges, falling edges or both.

A capture register can store the count when a chosen pin edge occurs. A clear option can reset both counters on another chosen edge. Together they measure a pulse width directly: clear on the leading edge and capture on the trailing edge. Software configures the block through a two-word write port. Word 0 is the control word and word 1 is the prescale limit.

Top module: `edgeTimer`

## Requirements
- R1: Control bits 1:0 select the mode. 00 is timer mode, 01 counts rising pin edges, 10 counts falling edges and 11 counts both edges. Only one of the prescaled step and the edge step can be active at a time.
- R2: Control bits 3:2 select the counted pin. 00 selects capIn[0] and 01 selects capIn[1]. With 10 or 11 selected, no edge is ever counted.
- R3: A pin change made before clock edge A appears at the outputs after edge A+2. Edges A and A+1 only move it through the two synchronizer flops.
- R4: In timer mode the prescale counter runs from 0 up to the limit written at cfgSel=1, then wraps. The count therefore advances once every limit+1 clocks.
- R5: With control bit 4 set, the clear event in bits 7:5 resets both the count and the prescale counter. 000 means rising on capIn[0], 001 falling on capIn[0], 010 rising on capIn[1] and 011 falling on capIn[1]. Codes 1xx, or bit 4 clear, disable the clear. The clear applies whether or not counting is enabled.
- R6: Control bits 12:10 choose the capture edge. 100 means rising on capIn[0], 101 falling on capIn[0], 110 rising on capIn[1] and 111 falling on capIn[1]; 0xx disables capture. On that edge capValue takes the count held before that clock's update. If a clear happens in the same cycle, capValue still gets the value before the clear.
- R7: Control bit 8 enables counting. While it is 0, the count and the prescale counter do not change, whatever the mode or the pin activity.
- R8: While control bit 9 is 1, both counters are held at zero.
- R9: After reset, count and capValue are 0 and the control word is all zero. The block is then stopped, in timer mode, with capIn[0] selected and clear and capture disabled.
- R10: The count wraps modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0: control word, 1: prescale limit |
| cfgData | input | 32 | Write data |
| capIn | input | 2 | Asynchronous capture pins |
| count | output | WIDTH | Timer/counter value |
| capValue | output | WIDTH | Captured count |

## Verification
The bench builds the block with WIDTH=8. At that width, wrap-around of the count (R10) takes 256 clocks, so it can be checked directly. The synchronizer depth stays at its default of two, so the three-edge latency and the clear/capture timing can be predicted exactly. The pulse-width result can be predicted for the same reason. A prescale limit of 3 and a limit of 0 together cover both the divided and the undivided timer step.

// File: rtl/edgeTimerPkg.sv
package edgeTimerPkg;
  localparam int CFG_W     = 32;
  localparam int CTRL_BITS = 13;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } modeT;

  typedef struct packed {
    logic preStep;  // timer-mode prescaler step
    logic cntStep;  // counter-mode edge step
    logic zero;     // clear both counters
    logic capture;  // latch count into capture register
  } strobeT;
endpackage

// File: rtl/edgeTimerCtrl.sv
module edgeTimerCtrl
  import edgeTimerPkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [CFG_W-1:0] cfgData,
  input  logic [1:0]       capIn,
  output logic [WIDTH-1:0] limit,
  output strobeT           strobe
);
  localparam int NUM_IN = 2;

  logic [CTRL_BITS-1:0] ctrlQ;
  logic [WIDTH-1:0]     limitQ;
  logic [NUM_IN-1:0]    riseV, fallV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      limitQ <= '0;
    end else if (cfgWe) begin
      if (cfgSel) limitQ <= cfgData[WIDTH-1:0];
      else        ctrlQ  <= cfgData[CTRL_BITS-1:0];
    end
  end

  // synchronizer stages plus one compare flop per pin
  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-1:0], capIn[i]};
    end
    assign riseV[i] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
    assign fallV[i] = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];
  end

  modeT mode;
  logic runEn, holdZero, clearEn;
  logic evtHit, clearHit, capHit;

  always_comb begin
    mode     = modeT'(ctrlQ[1:0]);
    runEn    = ctrlQ[8];
    holdZero = ctrlQ[9];
    clearEn  = ctrlQ[4];
    evtHit   = 1'b0;
    if (!ctrlQ[3]) begin
      unique case (mode)
        MODE_RISE: evtHit = riseV[ctrlQ[2]];
        MODE_FALL: evtHit = fallV[ctrlQ[2]];
        MODE_BOTH: evtHit = riseV[ctrlQ[2]] | fallV[ctrlQ[2]];
        default:   evtHit = 1'b0;
      endcase
    end
    clearHit = clearEn & ~ctrlQ[7] &
               (ctrlQ[5] ? fallV[ctrlQ[6]] : riseV[ctrlQ[6]]);
    capHit   = ctrlQ[12] &
               (ctrlQ[10] ? fallV[ctrlQ[11]] : riseV[ctrlQ[11]]);

    strobe.zero    = holdZero | clearHit;
    strobe.preStep = runEn & (mode == MODE_TIMER);
    strobe.cntStep = runEn & (mode != MODE_TIMER) & evtHit;
    strobe.capture = capHit;
  end

  assign limit = limitQ;
endmodule

// File: rtl/edgeTimerPath.sv
module edgeTimerPath
  import edgeTimerPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strobe,
  input  logic [WIDTH-1:0] limit,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capValue
);
  logic [WIDTH-1:0] preQ, cntQ, capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cntQ <= '0;
      capQ <= '0;
    end else begin
      if (strobe.capture) capQ <= cntQ;
      if (strobe.zero) begin
        preQ <= '0;
        cntQ <= '0;
      end else if (strobe.cntStep) begin
        cntQ <= cntQ + 1'b1;
      end else if (strobe.preStep) begin
        if (preQ == limit) begin
          preQ <= '0;
          cntQ <= cntQ + 1'b1;
        end else begin
          preQ <= preQ + 1'b1;
        end
      end
    end
  end

  assign count    = cntQ;
  assign capValue = capQ;
endmodule

// File: rtl/edgeTimer.sv
module edgeTimer
  import edgeTimerPkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgSel,
  input  logic [31:0]      cfgData,
  input  logic [1:0]       capIn,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] capValue
);
  strobeT           strobe;
  logic [WIDTH-1:0] limit;

  edgeTimerCtrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .capIn(capIn), .limit(limit), .strobe(strobe)
  );

  edgeTimerPath #(.WIDTH(WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .limit(limit),
    .count(count), .capValue(capValue)
  );
endmodule

// File: rtl/edgeTimerChk.sv
module edgeTimerChk
  import edgeTimerPkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input strobeT           strobe,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] capValue
);
  AST_ONE_STEP_KIND: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.preStep && strobe.cntStep)); // R1

  AST_ZERO_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zero |=> count == '0); // R5

  AST_EDGE_ADDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntStep && !strobe.zero) |=> count == $past(count) + 1'b1); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.zero && !strobe.cntStep && !strobe.preStep) |=> $stable(count)); // R7

  AST_CAP_TAKES_OLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> capValue == $past(count)); // R6

  AST_CAP_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(capValue)); // R6
endmodule

bind edgeTimer edgeTimerChk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .count(count), .capValue(capValue)
);

// File: tb/edgeTimer_bench.sv
module edgeTimer_bench;
  localparam int WIDTH = 8;
  localparam logic [31:0] RUN   = 32'h100;
  localparam logic [31:0] HOLD  = 32'h200;
  localparam logic [31:0] CLREN = 32'h010;

  // {mode[19:18], sel[17:16], pulses0[15:12], pulses1[11:8], expected[7:0]}
  localparam logic [19:0] VEC [7] = '{
    {2'b01, 2'b00, 4'd3, 4'd2, 8'd3},   // R1 R2 rising, pin 0
    {2'b01, 2'b01, 4'd3, 4'd2, 8'd2},   // R2 rising, pin 1
    {2'b10, 2'b00, 4'd4, 4'd1, 8'd4},   // R1 falling
    {2'b11, 2'b00, 4'd2, 4'd5, 8'd4},   // R1 both
    {2'b11, 2'b01, 4'd2, 4'd5, 8'd10},  // R1 both, pin 1
    {2'b01, 2'b10, 4'd3, 4'd3, 8'd0},   // R2 reserved
    {2'b10, 2'b11, 4'd2, 4'd2, 8'd0}    // R2 reserved
  };

  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic [1:0]  capIn = '0;
  logic [WIDTH-1:0] count, capValue, snap;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  edgeTimer #(.WIDTH(WIDTH)) u_edgeTimer (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .capIn(capIn), .count(count), .capValue(capValue)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input logic sel, input logic [31:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      capIn[idx] = 1'b1; repeat (3) @(negedge clk);
      capIn[idx] = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(count == 0, "R9 count", count, 0);
    chk(capValue == 0, "R9 capValue", capValue, 0);
    repeat (10) @(negedge clk);
    chk(count == 0, "R9 stopped after reset", count, 0);

    // table walk: counter mode
    for (int v = 0; v < 7; v++) begin
      wrCfg(1'b0, HOLD);
      wrCfg(1'b0, RUN | {28'd0, VEC[v][17:16], VEC[v][19:18]});
      pulse(0, int'(VEC[v][15:12]));
      pulse(1, int'(VEC[v][11:8]));
      repeat (5) @(negedge clk);
      chk(count == VEC[v][7:0], $sformatf("R1/R2 vector %0d", v), count, VEC[v][7:0]);
    end

    // R4 prescale limit 3
    wrCfg(1'b1, 32'd3);
    wrCfg(1'b0, HOLD | RUN);
    wrCfg(1'b0, RUN);
    repeat (19) @(negedge clk);
    chk(count == 4, "R4 limit3 19 clocks", count, 4);
    @(negedge clk);
    chk(count == 5, "R4 limit3 20 clocks", count, 5);

    // R4 limit 0, then R10 wrap
    wrCfg(1'b1, 32'd0);
    wrCfg(1'b0, HOLD | RUN);
    wrCfg(1'b0, RUN);
    repeat (10) @(negedge clk);
    chk(count == 10, "R4 limit0", count, 10);
    repeat (256) @(negedge clk);
    chk(count == 10, "R10 wrap", count, 10);

    // R7 enable off
    wrCfg(1'b0, 32'd0);
    snap = count;
    repeat (10) @(negedge clk);
    chk(count == snap, "R7 timer stopped", count, snap);
    wrCfg(1'b0, 32'h1);
    pulse(0, 2);
    repeat (5) @(negedge clk);
    chk(count == snap, "R7 edges ignored", count, snap);

    // R8 hold
    wrCfg(1'b0, RUN | HOLD);
    repeat (5) @(negedge clk);
    chk(count == 0, "R8 hold zero", count, 0);

    // R3 R5 R6 pulse width: clear rise pin1 (010), capture fall pin1 (111)
    wrCfg(1'b0, RUN | CLREN | (32'd2 << 5) | (32'd7 << 10));
    repeat (5) @(negedge clk);
    capIn[1] = 1'b1;
    @(negedge clk);
    chk(count != 0, "R3 not after 1 edge", count, 1);
    @(negedge clk);
    chk(count != 0, "R3 not after 2 edges", count, 1);
    @(negedge clk);
    chk(count == 0, "R3 R5 cleared after 3 edges", count, 0);
    repeat (4) @(negedge clk);
    capIn[1] = 1'b0;
    repeat (4) @(negedge clk);
    chk(capValue == 6, "R6 pulse width", capValue, 6);

    // R6 same-cycle clear and capture on rise pin0 (clear 000, capture 100)
    wrCfg(1'b0, RUN | CLREN | (32'd4 << 10));
    repeat (5) @(negedge clk);
    snap = count;
    capIn[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk(capValue == WIDTH'(snap + 2), "R6 capture before clear", capValue, WIDTH'(snap + 2));
    chk(count == 0, "R5 clear with capture", count, 0);
    capIn[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R5 clear disabled (bit 4 clear)
    wrCfg(1'b0, RUN);
    repeat (2) @(negedge clk);
    snap = count;
    pulse(0, 1);
    repeat (3) @(negedge clk);
    chk(count == WIDTH'(snap + 9), "R5 clear disabled", count, WIDTH'(snap + 9));

    // R5 reserved clear code 100 with enable set
    wrCfg(1'b0, RUN | CLREN | (32'd4 << 5));
    repeat (2) @(negedge clk);
    snap = count;
    pulse(0, 1);
    repeat (3) @(negedge clk);
    chk(count == WIDTH'(snap + 9), "R5 reserved code", count, WIDTH'(snap + 9));

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule